// File: doc/BRIEF.md
# DMA Bus Mastership Sequencer

This block runs the bus-request and grant handshake for a single DMA channel. Once a channel is started with a byte count, it watches an active-low transfer request. It raises a request for the shared system bus and, while the bus is granted, issues one read strobe and then one write strobe per transfer unit. It waits for the done pulse of each bus cycle, and decides from the latched bus mode whether to keep the bus or hand it back.

Three bus modes are supported:

- **Mode 1 (cycle steal, per unit).** The request is held across one read-plus-write unit and released afterwards.
- **Mode 2 (cycle steal, per cycle).** The request is released and raised again around the read cycle and around the write cycle separately.
- **Burst.** The request is held from the first unit until the count is exhausted.

Address generation, data movement and the bus protocol itself sit in neighbouring blocks. Those blocks consume the strobes, the count-decrement pulse and the end flag.

Top module: `dma_bus_seq`

## Requirements
- R1: After reset, bus_req, rd_stb, wr_stb, cnt_dec, xfer_end and chan_busy are 0 and cnt_left is 0.
- R2: A chan_start pulse while idle with a nonzero cnt_init loads cnt_left, latches the bus mode and unit size, and sets chan_busy. A pulse with cnt_init equal to zero is ignored. A pulse while chan_busy is 1 is ignored.
- R3: While busy and between units, bus_req is raised only after req_n is seen low. While req_n stays high, bus_req stays 0 and no strobe is issued.
- R4: Mode selection, latched at start:
  - burst_sel=1 selects burst.
  - burst_sel=0 with steal_mode=2'b00 and lock_sel=1 selects mode 2.
  - Every other setting with burst_sel=0 selects mode 1.
- R5: In mode 1, bus_req shows exactly one high interval per unit. That interval covers the read and the write, and bus_req drops in the cycle after the write done.
- R6: In mode 2, bus_req shows two high intervals per unit. It drops after the read done and after the write done, and stays low for at least one cycle before rising again.
- R7: In burst mode, bus_req shows one high interval for the whole transfer, and req_n is not consulted after the first unit starts.
- R8: rd_stb and wr_stb are single-cycle pulses, issued only while bus_gnt is 1. Without a grant the sequencer waits and loses no state.
- R9: unit_sel codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 16 and 32 bytes; codes 5 to 7 mean 1 byte. Each completed write lowers cnt_left by the unit size, saturating at 0, and pulses cnt_dec for one cycle in the cycle after that write done.
- R10: When the write done of a unit arrives with cnt_left at or below the unit size, xfer_end pulses for one cycle in the next cycle. In that same cycle chan_busy and bus_req fall, and no further request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_start | input | 1 | Channel start pulse |
| cnt_init | input | CNT_W | Byte count loaded at start |
| burst_sel | input | 1 | Burst select |
| lock_sel | input | 1 | Per-cycle re-arbitration select |
| steal_mode | input | 2 | Cycle-steal variant field, 00 = normal |
| unit_sel | input | 3 | Transfer unit size code |
| req_n | input | 1 | Active-low transfer request level |
| bus_gnt | input | 1 | Bus grant |
| rd_done | input | 1 | Read bus cycle finished |
| wr_done | input | 1 | Write bus cycle finished |
| bus_req | output | 1 | Bus request |
| rd_stb | output | 1 | Read cycle strobe |
| wr_stb | output | 1 | Write cycle strobe |
| cnt_dec | output | 1 | Count decremented pulse |
| xfer_end | output | 1 | Transfer end pulse |
| chan_busy | output | 1 | Channel active |
| cnt_left | output | CNT_W | Remaining byte count |

## Verification
The last write done of a transfer can land while req_n is still low. In that cycle the sequencer must choose between ending and re-requesting the bus. The bench keeps req_n low through whole transfers and requires exactly one end pulse, bus_req low afterwards, and no extra request interval.

Grant withdrawal can also coincide with a pending strobe. The bench holds the grant off after bus_req rises, then requires bus_req to stay high with no strobe and the unit to finish intact once the grant returns.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
package dma_seq_pkg;

    localparam int STEP_W = 6;

    typedef enum logic [1:0] {
        MODE_NORM1,
        MODE_NORM2,
        MODE_BURST
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_RD_ARB,
        ST_RD_BUSY,
        ST_WR_GAP,
        ST_WR_ARB,
        ST_WR_BUSY
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        bus_mode_e  mode;
        logic       bus_req;
        logic       dec;
        logic       fin;
    } seq_regs_t;

endpackage

// File: rtl/dma_mode_dec.sv
`timescale 1ns/1ps
module dma_mode_dec
    import dma_seq_pkg::*;
(
    input  logic       burst_i,
    input  logic       lock_i,
    input  logic [1:0] steal_i,
    output bus_mode_e  mode_o
);

    always_comb begin
        if (burst_i) begin
            mode_o = MODE_BURST;
        end else if (steal_i == 2'b00 && lock_i) begin
            mode_o = MODE_NORM2;
        end else begin
            mode_o = MODE_NORM1;
        end
    end

endmodule

// File: rtl/dma_unit_dec.sv
`timescale 1ns/1ps
module dma_unit_dec
    import dma_seq_pkg::*;
(
    input  logic [2:0]        unit_i,
    output logic [STEP_W-1:0] step_o
);

    always_comb begin
        case (unit_i)
            3'd0:    step_o = STEP_W'(1);
            3'd1:    step_o = STEP_W'(2);
            3'd2:    step_o = STEP_W'(4);
            3'd3:    step_o = STEP_W'(16);
            3'd4:    step_o = STEP_W'(32);
            default: step_o = STEP_W'(1);
        endcase
    end

endmodule

// File: rtl/dma_xfer_cnt.sv
`timescale 1ns/1ps
module dma_xfer_cnt
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CNT_W-1:0]  init_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic              dec_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              last_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
    } cnt_regs_t;

    cnt_regs_t d, q;
    logic [CNT_W-1:0] step_ext;

    assign step_ext = CNT_W'(q.step);

    always_comb begin
        d = q;
        if (load_i) begin
            d.cnt  = init_i;
            d.step = step_i;
        end else if (dec_i) begin
            d.cnt = (q.cnt <= step_ext) ? '0 : q.cnt - step_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o  = q.cnt;
    assign last_o = (q.cnt <= step_ext);

    // R9: each decrement shrinks the remaining count
    assert_cnt_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && q.cnt != '0) |=> (q.cnt < $past(q.cnt)));

    // R9: the final unit saturates the count at zero
    assert_cnt_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && last_o) |=> (q.cnt == '0));

endmodule

// File: rtl/dma_bus_fsm.sv
`timescale 1ns/1ps
module dma_bus_fsm
    import dma_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      cnt_nz_i,
    input  bus_mode_e mode_i,
    input  logic      req_n_i,
    input  logic      gnt_i,
    input  logic      rd_done_i,
    input  logic      wr_done_i,
    input  logic      last_i,
    output logic      load_o,
    output logic      dec_now_o,
    output logic      bus_req_o,
    output logic      rd_stb_o,
    output logic      wr_stb_o,
    output logic      dec_o,
    output logic      end_o,
    output logic      busy_o
);

    seq_regs_t d, q;

    always_comb begin
        d         = q;
        d.dec     = 1'b0;
        d.fin     = 1'b0;
        load_o    = 1'b0;
        dec_now_o = 1'b0;
        rd_stb_o  = 1'b0;
        wr_stb_o  = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i && cnt_nz_i) begin
                    load_o  = 1'b1;
                    d.mode  = mode_i;
                    d.state = ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (!req_n_i) begin
                    d.bus_req = 1'b1;
                    d.state   = ST_RD_ARB;
                end
            end
            ST_RD_ARB: begin
                if (gnt_i && q.bus_req) begin
                    rd_stb_o = 1'b1;
                    d.state  = ST_RD_BUSY;
                end
            end
            ST_RD_BUSY: begin
                if (rd_done_i) begin
                    if (q.mode == MODE_NORM2) begin
                        d.bus_req = 1'b0;
                        d.state   = ST_WR_GAP;
                    end else begin
                        d.state = ST_WR_ARB;
                    end
                end
            end
            ST_WR_GAP: begin
                d.bus_req = 1'b1;
                d.state   = ST_WR_ARB;
            end
            ST_WR_ARB: begin
                if (gnt_i && q.bus_req) begin
                    wr_stb_o = 1'b1;
                    d.state  = ST_WR_BUSY;
                end
            end
            ST_WR_BUSY: begin
                if (wr_done_i) begin
                    dec_now_o = 1'b1;
                    d.dec     = 1'b1;
                    if (last_i) begin
                        d.fin     = 1'b1;
                        d.bus_req = 1'b0;
                        d.state   = ST_IDLE;
                    end else if (q.mode == MODE_BURST) begin
                        d.state = ST_RD_ARB;
                    end else begin
                        d.bus_req = 1'b0;
                        d.state   = ST_WAIT_REQ;
                    end
                end
            end
            default: begin
                d.state   = ST_IDLE;
                d.bus_req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, mode: MODE_NORM1, bus_req: 1'b0, dec: 1'b0, fin: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign bus_req_o = q.bus_req;
    assign dec_o     = q.dec;
    assign end_o     = q.fin;
    assign busy_o    = (q.state != ST_IDLE);

    // R8: a read strobe only ever appears under a grant
    assert_rd_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_o |-> gnt_i);

    // R10: the end flag follows a write done and leaves the channel idle
    assert_end_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.fin |-> ($past(wr_done_i) && !busy_o && !q.bus_req));

    // R7: in burst mode the request falls only together with the end flag
    assert_burst_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_BURST && $fell(q.bus_req)) |-> q.fin);

    // R6: in mode 2 a read done releases the bus at once
    assert_norm2_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_NORM2 && q.state == ST_RD_BUSY && rd_done_i) |=> !q.bus_req);

    // R5: in mode 1 the request stays up from read done to write strobe
    assert_norm1_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode == MODE_NORM1 && q.state == ST_RD_BUSY && rd_done_i) |=> q.bus_req);

endmodule

// File: rtl/dma_bus_seq.sv
`timescale 1ns/1ps
module dma_bus_seq
    import dma_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_start,
    input  logic [CNT_W-1:0] cnt_init,
    input  logic             burst_sel,
    input  logic             lock_sel,
    input  logic [1:0]       steal_mode,
    input  logic [2:0]       unit_sel,
    input  logic             req_n,
    input  logic             bus_gnt,
    input  logic             rd_done,
    input  logic             wr_done,
    output logic             bus_req,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             cnt_dec,
    output logic             xfer_end,
    output logic             chan_busy,
    output logic [CNT_W-1:0] cnt_left
);

    bus_mode_e         mode_sel;
    logic [STEP_W-1:0] step_sel;
    logic              load;
    logic              dec_now;
    logic              last;

    dma_mode_dec u_mode (
        .burst_i (burst_sel),
        .lock_i  (lock_sel),
        .steal_i (steal_mode),
        .mode_o  (mode_sel)
    );

    dma_unit_dec u_unit (
        .unit_i (unit_sel),
        .step_o (step_sel)
    );

    dma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .init_i (cnt_init),
        .step_i (step_sel),
        .dec_i  (dec_now),
        .cnt_o  (cnt_left),
        .last_o (last)
    );

    dma_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (chan_start),
        .cnt_nz_i  (|cnt_init),
        .mode_i    (mode_sel),
        .req_n_i   (req_n),
        .gnt_i     (bus_gnt),
        .rd_done_i (rd_done),
        .wr_done_i (wr_done),
        .last_i    (last),
        .load_o    (load),
        .dec_now_o (dec_now),
        .bus_req_o (bus_req),
        .rd_stb_o  (rd_stb),
        .wr_stb_o  (wr_stb),
        .dec_o     (cnt_dec),
        .end_o     (xfer_end),
        .busy_o    (chan_busy)
    );

endmodule

// File: tb/dma_bus_seq_test.sv
`timescale 1ns/1ps
module dma_bus_seq_test;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             chan_start = 1'b0;
    logic [CNT_W-1:0] cnt_init = '0;
    logic             burst_sel = 1'b0;
    logic             lock_sel = 1'b0;
    logic [1:0]       steal_mode = 2'b00;
    logic [2:0]       unit_sel = 3'd0;
    logic             req_n = 1'b1;
    logic             bus_gnt = 1'b0;
    logic             rd_done = 1'b0;
    logic             wr_done = 1'b0;
    logic             bus_req, rd_stb, wr_stb, cnt_dec, xfer_end, chan_busy;
    logic [CNT_W-1:0] cnt_left;

    always #2.5 clk = ~clk;

    dma_bus_seq #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .chan_start(chan_start), .cnt_init(cnt_init),
        .burst_sel(burst_sel), .lock_sel(lock_sel), .steal_mode(steal_mode),
        .unit_sel(unit_sel), .req_n(req_n), .bus_gnt(bus_gnt), .rd_done(rd_done),
        .wr_done(wr_done), .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .cnt_dec(cnt_dec), .xfer_end(xfer_end), .chan_busy(chan_busy), .cnt_left(cnt_left)
    );

    int n_chk = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_rise = 0, n_dec = 0, n_end = 0, n_bad = 0;
    int rd_wait = 0, wr_wait = 0;
    bit prev_req = 1'b0;
    bit gnt_block = 1'b0;

    // bus model: grant follows request, done pulses two cycles after a strobe
    always @(negedge clk) begin
        if (rst_n) begin
            bus_gnt = bus_req & ~gnt_block;
            rd_done = (rd_wait == 1);
            wr_done = (wr_wait == 1);
            if (rd_wait != 0) rd_wait = rd_wait - 1;
            if (wr_wait != 0) wr_wait = wr_wait - 1;
            #1;
            if (bus_req && !prev_req) n_rise = n_rise + 1;
            prev_req = bus_req;
            if (rd_stb) begin n_rd = n_rd + 1; rd_wait = 2; if (!bus_gnt) n_bad = n_bad + 1; end
            if (wr_stb) begin n_wr = n_wr + 1; wr_wait = 2; if (!bus_gnt) n_bad = n_bad + 1; end
            if (cnt_dec) n_dec = n_dec + 1;
            if (xfer_end) n_end = n_end + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic start_chan(input int cnt, input bit tb, input bit lk,
                              input logic [1:0] cms, input logic [2:0] u);
        @(negedge clk);
        cnt_init = CNT_W'(cnt); burst_sel = tb; lock_sel = lk;
        steal_mode = cms; unit_sel = u; chan_start = 1'b1;
        @(negedge clk);
        chan_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && chan_busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        #2;
    endtask

    // run a whole transfer with req_n held low, check units and request intervals
    task automatic run_full(input string tag, input int cnt, input bit tb, input bit lk,
                            input logic [1:0] cms, input logic [2:0] u,
                            input int units, input int rises);
        int b_wr, b_rise, b_dec, b_end;
        b_wr = n_wr; b_rise = n_rise; b_dec = n_dec; b_end = n_end;
        req_n = 1'b0;
        start_chan(cnt, tb, lk, cms, u);
        wait_idle();
        req_n = 1'b1;
        chk({tag, " units"}, n_wr - b_wr, units);
        chk({tag, " cnt_dec pulses R9"}, n_dec - b_dec, units);
        chk({tag, " request intervals"}, n_rise - b_rise, rises);
        chk({tag, " end pulses R10"}, n_end - b_end, 1);
        chk({tag, " bus_req after end R10"}, int'(bus_req), 0);
        chk({tag, " cnt_left after end R9"}, int'(cnt_left), 0);
    endtask

    task automatic test_reset();
        #2;
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 chan_busy", int'(chan_busy), 0);
        chk("R1 strobes", int'(rd_stb | wr_stb), 0);
        chk("R1 end/dec", int'(xfer_end | cnt_dec), 0);
        chk("R1 cnt_left", int'(cnt_left), 0);
    endtask

    task automatic test_modes();
        run_full("R5 mode1 byte", 4, 1'b0, 1'b0, 2'b00, 3'd0, 4, 4);
        run_full("R6 mode2 word", 8, 1'b0, 1'b1, 2'b00, 3'd1, 4, 8);
        run_full("R7 burst 16B", 64, 1'b1, 1'b1, 2'b10, 3'd3, 4, 1);
        run_full("R4 cms01 lock as mode1", 8, 1'b0, 1'b1, 2'b01, 3'd2, 2, 2);
        run_full("R6 mode2 32B", 96, 1'b0, 1'b1, 2'b00, 3'd4, 3, 6);
        run_full("R9 residual word", 5, 1'b0, 1'b0, 2'b00, 3'd1, 3, 3);
        run_full("R9 reserved size", 3, 1'b0, 1'b0, 2'b11, 3'd6, 3, 3);
    endtask

    task automatic test_burst_ignores_req();
        int b_wr, b_rise;
        b_wr = n_wr; b_rise = n_rise;
        req_n = 1'b0;
        start_chan(8, 1'b1, 1'b0, 2'b00, 3'd0);
        for (int i = 0; i < 100 && (n_rd == 0 || n_rd == b_wr); i++) @(negedge clk);
        req_n = 1'b1;
        wait_idle();
        chk("R7 burst continues without req", n_wr - b_wr, 8);
        chk("R7 burst single interval", n_rise - b_rise, 1);
    endtask

    task automatic test_request();
        int b_rd;
        b_rd = n_rd;
        req_n = 1'b1;
        start_chan(2, 1'b0, 1'b0, 2'b00, 3'd0);
        repeat (10) @(negedge clk);
        #2;
        chk("R2 busy after start", int'(chan_busy), 1);
        chk("R2 count loaded", int'(cnt_left), 2);
        chk("R3 no bus_req without request", int'(bus_req), 0);
        chk("R3 no read without request", n_rd - b_rd, 0);
        req_n = 1'b0;
        for (int i = 0; i < 50 && n_wr == b_rd; i++) @(negedge clk);
        req_n = 1'b1;
        repeat (20) @(negedge clk);
        #2;
        chk("R3 stops after one unit", n_rd - b_rd, 1);
        chk("R3 bus released between units", int'(bus_req), 0);
        chk("R3 count after one unit", int'(cnt_left), 1);
        req_n = 1'b0;
        wait_idle();
        req_n = 1'b1;
        chk("R3 resumes on request", n_rd - b_rd, 2);
    endtask

    task automatic test_grant_wait();
        int b_rd, b_wr, b_rise;
        b_rd = n_rd; b_wr = n_wr; b_rise = n_rise;
        gnt_block = 1'b1;
        req_n = 1'b0;
        start_chan(1, 1'b0, 1'b1, 2'b00, 3'd0);
        repeat (10) @(negedge clk);
        #2;
        chk("R8 request held while waiting", int'(bus_req), 1);
        chk("R8 no read without grant", n_rd - b_rd, 0);
        gnt_block = 1'b0;
        wait_idle();
        req_n = 1'b1;
        chk("R8 read after grant", n_rd - b_rd, 1);
        chk("R8 write after grant", n_wr - b_wr, 1);
        chk("R6 two intervals after wait", n_rise - b_rise, 2);
        chk("R8 strobes without grant", n_bad, 0);
    endtask

    task automatic test_ignored_starts();
        int b_wr;
        start_chan(0, 1'b0, 1'b0, 2'b00, 3'd0);
        #2;
        chk("R2 zero count ignored busy", int'(chan_busy), 0);
        chk("R2 zero count ignored cnt", int'(cnt_left), 0);
        b_wr = n_wr;
        req_n = 1'b0;
        start_chan(3, 1'b0, 1'b0, 2'b00, 3'd0);
        repeat (3) @(negedge clk);
        start_chan(100, 1'b1, 1'b0, 2'b00, 3'd0);
        wait_idle();
        req_n = 1'b1;
        chk("R2 start while busy ignored", n_wr - b_wr, 3);
        chk("R2 count after ignored start", int'(cnt_left), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                test_reset();
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                test_modes();
                test_burst_ignores_req();
                test_request();
                test_grant_wait();
                test_ignored_starts();
            end
            begin
                repeat (150000) @(posedge clk);
                n_chk = n_chk + 1;
                n_fail = n_fail + 1;
                $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule